// File: doc/BRIEF.md
# Four-Source Interrupt Flag and Enable Controller

This block collects interrupt events for a small 8-bit microcontroller core and turns them into one request line. Four event sources feed it: an edge on a single external pin, a level change on any of four upper port pins, a timer overflow pulse, and a completion pulse from the nonvolatile-memory write engine. Each source owns a sticky pending flag and an enable bit. A global enable gates the combined result. Software reaches the flags and enables through a small register port with address, write strobe, write data and combinational read data.

The external pin and the four port pins are asynchronous. Each passes through a two-stage synchronizer before detection. The pin edge detector watches for a rising or a falling edge, chosen by an option bit. The port detector compares the four synchronized pins against the value it latched on the previous cycle.

A two-state service machine tracks whether the core is servicing an interrupt. In state `SVC_IDLE`, an accept pulse from the core (`core_ack`) while `irq_req` is high takes the transition IDLE→ACTIVE and clears the global enable. In state `SVC_ACTIVE`, a return pulse (`core_reti`) takes the transition ACTIVE→IDLE and sets the global enable again. In every other case the machine stays where it is.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the option register (address 1) reads 0x40, the auxiliary register (address 2) reads 0x00, and `irq_req` is low. Address 3 always reads 0x00.
- R2: `irq_req` is high exactly when the global enable is set and at least one source has both its flag and its enable set.
- R3: An edge on `ext_pin` sets control bit 1. The edge is rising when option bit 6 is 1 and falling when option bit 6 is 0. An edge of the other direction is ignored. The flag is visible within four cycles of the pin change.
- R4: A change of state on any one of the four `port_pins` sets control bit 0.
- R5: A `tmr_ovf` pulse sets control bit 2 on the next clock edge, whether or not the timer enable is set.
- R6: A `nvm_done` pulse sets auxiliary bit 0 on the next clock edge. Auxiliary bit 1 is that source's enable.
- R7: Flags are sticky and change only when software writes them. Writing a 0 clears a flag. When a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.
- R8: Control register layout: bit 7 is the global enable, bit 5 the timer enable, bit 4 the pin enable and bit 3 the port enable. Bit 6 is not stored and reads 0.
- R9: `core_ack` in `SVC_IDLE` while `irq_req` is high clears the global enable on the next edge and enters `SVC_ACTIVE`.
- R10: `core_reti` in `SVC_ACTIVE` sets the global enable and returns to `SVC_IDLE`. `core_reti` in `SVC_IDLE` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 option, 2 auxiliary |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 4 | Asynchronous upper port pins watched for change |
| tmr_ovf | input | 1 | Timer overflow pulse |
| nvm_done | input | 1 | Nonvolatile-memory write completion pulse |
| core_ack | input | 1 | Core accepts the pending interrupt |
| core_reti | input | 1 | Core returns from the interrupt routine |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The request logic is tried with random mixes of enable bits, global enable, flag writes and event pulses. A bench model predicts the request for each mix, which tells an enabled flag apart from a disabled one and exposes any source that ignores the global gate. Directed pin sequences are run under both polarities. They separate the wanted edge from the opposite edge and show that each of the four port pins reaches the change flag on its own. Same-cycle set and clear, accept pulses, and return pulses given in each service state are aimed at the priority rules and the two service transitions.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int unsigned CTL_GIE      = 7;
    localparam int unsigned CTL_TMR_EN   = 5;
    localparam int unsigned CTL_PIN_EN   = 4;
    localparam int unsigned CTL_PORT_EN  = 3;
    localparam int unsigned CTL_TMR_FLG  = 2;
    localparam int unsigned CTL_PIN_FLG  = 1;
    localparam int unsigned CTL_PORT_FLG = 0;
    localparam int unsigned OPT_RISE     = 6;
    localparam int unsigned AUX_NVM_EN   = 1;
    localparam int unsigned AUX_NVM_FLG  = 0;

    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_OPT = 2'd1,
        REG_AUX = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SVC_IDLE   = 1'b0,
        SVC_ACTIVE = 1'b1
    } svc_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    assign hit = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_s,
    output logic             hit
);
    logic [WIDTH-1:0] latched_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latched_q <= '0;
        else        latched_q <= pins_s;
    end

    assign hit = |(pins_s ^ latched_q);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned PORT_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              tmr_ovf,
    input  logic              nvm_done,
    input  logic              core_ack,
    input  logic              core_reti,
    output logic              irq_req
);
    localparam int unsigned SYNC_W = PORT_W + 1;

    svc_state_e state_q, state_d;
    logic gie_q, gie_d;
    logic tmr_en_q, pin_en_q, port_en_q, nvm_en_q, rise_q;
    logic tmr_flg_q, pin_flg_q, port_flg_q, nvm_flg_q;
    logic [SYNC_W-1:0] sync_q;
    logic pin_hit, port_hit;
    logic wr_ctl, wr_opt, wr_aux;

    irq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({port_pins, ext_pin}), .q(sync_q)
    );

    irq_pin_edge u_pin_edge (
        .clk(clk), .rst_n(rst_n), .pin_s(sync_q[0]), .rise_sel(rise_q), .hit(pin_hit)
    );

    irq_port_change #(.WIDTH(PORT_W)) u_port_chg (
        .clk(clk), .rst_n(rst_n), .pins_s(sync_q[SYNC_W-1:1]), .hit(port_hit)
    );

    assign wr_ctl = reg_wr && (reg_sel_e'(reg_addr) == REG_CTL);
    assign wr_opt = reg_wr && (reg_sel_e'(reg_addr) == REG_OPT);
    assign wr_aux = reg_wr && (reg_sel_e'(reg_addr) == REG_AUX);

    // Service state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    // Next state and global enable update
    always_comb begin
        state_d = state_q;
        gie_d   = wr_ctl ? reg_wdata[CTL_GIE] : gie_q;
        unique case (state_q)
            SVC_IDLE: begin
                if (core_ack && irq_req) begin
                    state_d = SVC_ACTIVE;
                    gie_d   = 1'b0;
                end
            end
            SVC_ACTIVE: begin
                if (core_reti) begin
                    state_d = SVC_IDLE;
                    gie_d   = 1'b1;
                end
            end
            default: state_d = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q      <= 1'b0;
            tmr_en_q   <= 1'b0;
            pin_en_q   <= 1'b0;
            port_en_q  <= 1'b0;
            nvm_en_q   <= 1'b0;
            rise_q     <= 1'b1;
            tmr_flg_q  <= 1'b0;
            pin_flg_q  <= 1'b0;
            port_flg_q <= 1'b0;
            nvm_flg_q  <= 1'b0;
        end else begin
            gie_q <= gie_d;
            if (wr_ctl) begin
                tmr_en_q  <= reg_wdata[CTL_TMR_EN];
                pin_en_q  <= reg_wdata[CTL_PIN_EN];
                port_en_q <= reg_wdata[CTL_PORT_EN];
            end
            if (wr_opt) rise_q   <= reg_wdata[OPT_RISE];
            if (wr_aux) nvm_en_q <= reg_wdata[AUX_NVM_EN];
            // hardware set takes priority over a same-cycle software write
            tmr_flg_q  <= tmr_ovf  | (wr_ctl ? reg_wdata[CTL_TMR_FLG]  : tmr_flg_q);
            pin_flg_q  <= pin_hit  | (wr_ctl ? reg_wdata[CTL_PIN_FLG]  : pin_flg_q);
            port_flg_q <= port_hit | (wr_ctl ? reg_wdata[CTL_PORT_FLG] : port_flg_q);
            nvm_flg_q  <= nvm_done | (wr_aux ? reg_wdata[AUX_NVM_FLG]  : nvm_flg_q);
        end
    end

    // Outputs
    always_comb begin
        irq_req = gie_q & ((tmr_en_q & tmr_flg_q) | (pin_en_q & pin_flg_q) |
                           (port_en_q & port_flg_q) | (nvm_en_q & nvm_flg_q));
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            REG_CTL: begin
                reg_rdata[CTL_GIE]      = gie_q;
                reg_rdata[CTL_TMR_EN]   = tmr_en_q;
                reg_rdata[CTL_PIN_EN]   = pin_en_q;
                reg_rdata[CTL_PORT_EN]  = port_en_q;
                reg_rdata[CTL_TMR_FLG]  = tmr_flg_q;
                reg_rdata[CTL_PIN_FLG]  = pin_flg_q;
                reg_rdata[CTL_PORT_FLG] = port_flg_q;
            end
            REG_OPT: reg_rdata[OPT_RISE] = rise_q;
            REG_AUX: begin
                reg_rdata[AUX_NVM_EN]  = nvm_en_q;
                reg_rdata[AUX_NVM_FLG] = nvm_flg_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       tmr_ovf,
    input logic       nvm_done,
    input logic       core_ack,
    input logic       core_reti,
    input logic       irq_req,
    input logic       gie,
    input logic       tmr_flg,
    input logic       nvm_flg,
    input logic       svc_active
);
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie); // R2
    AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> tmr_flg); // R5
    AST_NVM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_done |=> nvm_flg); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_flg && !(reg_wr && reg_addr == 2'd0)) |=> tmr_flg); // R7
    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && irq_req && !svc_active) |=> (!gie && svc_active)); // R9
    AST_RETI_RESTORES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_reti && svc_active) |=> (gie && !svc_active)); // R10
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .tmr_ovf(tmr_ovf), .nvm_done(nvm_done), .core_ack(core_ack),
    .core_reti(core_reti), .irq_req(irq_req), .gie(gie_q),
    .tmr_flg(tmr_flg_q), .nvm_flg(nvm_flg_q),
    .svc_active(state_q == irq_ctrl_pkg::SVC_ACTIVE)
);

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_pin = 1'b0;
    logic [3:0] port_pins = 4'h0;
    logic       tmr_ovf = 1'b0;
    logic       nvm_done = 1'b0;
    logic       core_ack = 1'b0;
    logic       core_reti = 1'b0;
    logic       irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] rv;
    logic [7:0] mdl_ctl;
    logic [7:0] mdl_aux;

    always #5 clk = ~clk;

    irq_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .port_pins(port_pins), .tmr_ovf(tmr_ovf), .nvm_done(nvm_done),
        .core_ack(core_ack), .core_reti(core_reti), .irq_req(irq_req)
    );

    function automatic logic exp_req(input logic [7:0] c, input logic [7:0] a);
        return c[7] & ((c[5] & c[2]) | (c[4] & c[1]) | (c[3] & c[0]) | (a[1] & a[0]));
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
    endtask

    task automatic pulse_nvm();
        @(negedge clk); nvm_done = 1'b1;
        @(negedge clk); nvm_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(2'd0, rv); check("R1 ctl", rv, 8'h00);
        rd(2'd1, rv); check("R1 opt", rv, 8'h40);
        rd(2'd2, rv); check("R1 aux", rv, 8'h00);
        rd(2'd3, rv); check("R1 addr3", rv, 8'h00);
        check("R1 irq", {7'd0, irq_req}, 8'h00);

        // R8 layout: bit 6 not stored; R2 request with everything set
        wr(2'd0, 8'hFF);
        rd(2'd0, rv); check("R8 ctl layout", rv, 8'hBF);
        check("R2 all set", {7'd0, irq_req}, 8'h01);
        wr(2'd0, 8'h38);
        check("R2 no gie", {7'd0, irq_req}, 8'h00);
        wr(2'd0, 8'h00);

        // R3 rising edge default
        @(negedge clk); ext_pin = 1'b1; wait_cyc(4);
        rd(2'd0, rv); check("R3 rising sets", rv, 8'h02);
        wr(2'd0, 8'h00);
        @(negedge clk); ext_pin = 1'b0; wait_cyc(4);
        rd(2'd0, rv); check("R3 falling ignored", rv, 8'h00);
        // R3 falling polarity
        wr(2'd1, 8'h00);
        @(negedge clk); ext_pin = 1'b1; wait_cyc(4);
        rd(2'd0, rv); check("R3 rising ignored", rv, 8'h00);
        @(negedge clk); ext_pin = 1'b0; wait_cyc(4);
        rd(2'd0, rv); check("R3 falling sets", rv, 8'h02);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        rd(2'd1, rv); check("R3 opt readback", rv, 8'h40);

        // R4 each port pin alone
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); port_pins[i] = ~port_pins[i]; wait_cyc(4);
            rd(2'd0, rv); check($sformatf("R4 pin %0d", i), rv, 8'h01);
            wr(2'd0, 8'h00);
            rd(2'd0, rv); check("R7 clear by write 0", rv, 8'h00);
        end

        // R5 timer flag without enable
        pulse_tmr();
        rd(2'd0, rv); check("R5 flag w/o enable", rv, 8'h04);
        check("R5 no irq", {7'd0, irq_req}, 8'h00);
        wait_cyc(3);
        rd(2'd0, rv); check("R7 sticky", rv, 8'h04);
        wr(2'd0, 8'h00);

        // R7 hardware set wins over clear in same cycle
        @(negedge clk);
        reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        rd(2'd0, rv); check("R7 set wins", rv, 8'h04);
        wr(2'd0, 8'h00);

        // R6 memory-write source
        pulse_nvm();
        rd(2'd2, rv); check("R6 flag", rv, 8'h01);
        wr(2'd0, 8'h80);
        check("R6 gated by enable", {7'd0, irq_req}, 8'h00);
        wr(2'd2, 8'h03);
        check("R6 irq", {7'd0, irq_req}, 8'h01);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);

        // R10 return while idle ignored
        @(negedge clk); core_reti = 1'b1;
        @(negedge clk); core_reti = 1'b0;
        rd(2'd0, rv); check("R10 reti idle ignored", rv, 8'h00);

        // R9 accept clears global enable
        wr(2'd0, 8'hA4);
        check("R2 timer irq", {7'd0, irq_req}, 8'h01);
        @(negedge clk); core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
        rd(2'd0, rv); check("R9 gie cleared", rv, 8'h24);
        check("R9 irq drops", {7'd0, irq_req}, 8'h00);
        // R10 return restores
        @(negedge clk); core_reti = 1'b1;
        @(negedge clk); core_reti = 1'b0;
        rd(2'd0, rv); check("R10 gie set", rv, 8'hA4);
        check("R10 irq back", {7'd0, irq_req}, 8'h01);
        wr(2'd0, 8'h00);

        // R2 random mixes
        mdl_ctl = 8'h00; mdl_aux = 8'h00;
        for (int n = 0; n < 200; n++) begin
            logic [31:0] v;
            v = $urandom;
            wr(2'd0, v[7:0]);  mdl_ctl = v[7:0] & 8'hBF;
            wr(2'd2, {6'd0, v[9:8]}); mdl_aux = {6'd0, v[9:8]};
            if (v[10]) begin pulse_tmr(); mdl_ctl[2] = 1'b1; end
            if (v[11]) begin pulse_nvm(); mdl_aux[0] = 1'b1; end
            rd(2'd0, rv); check("R2 rand ctl", rv, mdl_ctl);
            rd(2'd2, rv); check("R6 rand aux", rv, mdl_aux);
            check("R2 rand irq", {7'd0, irq_req}, {7'd0, exp_req(mdl_ctl, mdl_aux)});
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule